// File: doc/BRIEF.md
# Program/Erase Engine Status Register

This block keeps the status byte that a host reads while an internal program or erase engine works on the array. The engine reports start, done and failure events. The command decoder passes on suspend and resume requests, the engine acknowledges a suspend once it has parked, and software can issue a clear-status command. The block returns those events as four meaningful status bits. Its low nibble is always zero.

A host read is framed by a read strobe. The status value is frozen when the strobe rises, so one access never sees a half-updated byte. A new value appears only after the strobe drops and rises again. The block also drives a ready/busy level meant for an open-drain pin.

The block raises an inhibit signal while either failure bit is set. The inhibit tells the command decoder that no new program or erase may begin, and the block itself ignores start events while it is high. A power-down input wipes the whole register.

Top module: `wsm_status_reg`

## Requirements
- R1: After reset the read data is 0x0080, `rdy_level` is 1 and `op_inhibit` is 0.
- R2: Status layout is bit 7 = ready (1 idle, 0 busy), bit 6 = erase suspended, bit 5 = erase failed, bit 4 = program failed, and bits 3..0 always 0. With `word_mode` = 1 the bits above 7 read 0x00 and `upper_en` is 1. With `word_mode` = 0, `upper_en` is 0.
- R3: An accepted `eng_start` clears bit 7 and drives `rdy_level` low. `eng_done` sets bit 7 and drives `rdy_level` high.
- R4: Bits 4 and 5 are cleared only by `clr_stat` or by power-down. Engine events never clear them. A failure pulse in the same cycle as `clr_stat` leaves its bit set.
- R5: While bit 4 or bit 5 is set, `op_inhibit` is 1 and `eng_start` is ignored: bit 7 stays 1 and `rdy_level` stays high.
- R6: `susp_req` during a busy erase sets bit 6 while bit 7 stays 0 and `rdy_level` stays low. A later `susp_ack` sets bit 7 and drives `rdy_level` high. `susp_req` during a program has no effect.
- R7: `resume_req` while suspended clears bit 6, clears bit 7 and drives `rdy_level` low. In any other state it has no effect.
- R8: The read value is captured on the rising edge of `rd_strobe` and held while the strobe stays high. Changes made during that time appear only on the next rising edge.
- R9: `eng_done` together with a failure pulse in one cycle sets bit 7 and the matching failure bit together.
- R10: While `pwr_down` is 1 the read data is 0x0000, `rdy_level` is 1 and `op_inhibit` is 0. All bits are cleared. After release, the next read returns 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down level; clears all status |
| word_mode | input | 1 | 1 = wide data bus, 0 = byte bus |
| eng_start | input | 1 | Engine begins an operation (pulse) |
| start_erase | input | 1 | Qualifies `eng_start`: 1 = erase, 0 = program |
| eng_done | input | 1 | Engine finished its operation (pulse) |
| prog_fail | input | 1 | Program failure event (pulse) |
| erase_fail | input | 1 | Erase failure event (pulse) |
| susp_req | input | 1 | Erase suspend requested (pulse) |
| susp_ack | input | 1 | Engine reached the suspended state (pulse) |
| resume_req | input | 1 | Erase resume requested (pulse) |
| clr_stat | input | 1 | Clear-status command (pulse) |
| rd_strobe | input | 1 | Read access active; rising edge captures status |
| stat_data | output | DATA_W | Captured status, zero-padded above bit 7 |
| upper_en | output | 1 | Upper data byte is driven (word mode) |
| rdy_level | output | 1 | Ready/busy level; low only while the engine is busy |
| op_inhibit | output | 1 | New program/erase must not start |

## Verification
The bench builds the block with its default 16-bit data width. This exposes the zero padding of the upper byte and lets the upper-enable output be checked in both bus modes. The same build carries the full suspend/resume handshake, fail bits that survive completion and a clear-status pulse that coincides with a failure, so their interactions can be observed across a frozen read.

// File: rtl/wsm_stat_pkg.sv
// Package: shared status byte layout for the engine status register.
// Assumes an 8-bit status byte; bit positions are fixed by the host view.
package wsm_stat_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic       ready;    // bit 7
        logic       susp;     // bit 6
        logic       efail;    // bit 5
        logic       pfail;    // bit 4
        logic [3:0] rsvd;     // bits 3..0, always zero
    } stat_byte_t;

    localparam stat_byte_t STAT_IDLE = '{ready: 1'b1, susp: 1'b0, efail: 1'b0,
                                         pfail: 1'b0, rsvd: 4'h0};
    localparam stat_byte_t STAT_ZERO = '{default: '0};
endpackage

// File: rtl/wsm_stat_bits.sv
// Module: live status state. Tracks busy, erase-op, suspend and sticky fail
// bits from engine and command events. Assumes events are one-cycle pulses.
module wsm_stat_bits
    import wsm_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       eng_start,
    input  logic       start_erase,
    input  logic       eng_done,
    input  logic       prog_fail,
    input  logic       erase_fail,
    input  logic       susp_req,
    input  logic       susp_ack,
    input  logic       resume_req,
    input  logic       clr_stat,
    output stat_byte_t live,
    output logic       busy,
    output logic       inhibit
);
    logic busy_q, erase_op_q, susp_q, pfail_q, efail_q;
    logic start_ok;

    // Accept a start only when idle, not suspended and no fail is pending.
    assign start_ok = eng_start && !busy_q && !susp_q && !inhibit;

    // Busy / operation-type / suspend sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            busy_q     <= 1'b0;
            erase_op_q <= 1'b0;
            susp_q     <= 1'b0;
        end else begin
            if (start_ok) begin
                busy_q     <= 1'b1;
                erase_op_q <= start_erase;
            end
            if (eng_done && busy_q)
                busy_q <= 1'b0;
            if (susp_req && busy_q && erase_op_q && !susp_q)
                susp_q <= 1'b1;
            if (susp_ack && susp_q && busy_q)
                busy_q <= 1'b0;
            if (resume_req && susp_q && !busy_q) begin
                susp_q <= 1'b0;
                busy_q <= 1'b1;
            end
        end
    end

    // Sticky fail bits: cleared by software only, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            pfail_q <= 1'b0;
            efail_q <= 1'b0;
        end else begin
            if (clr_stat) begin
                pfail_q <= 1'b0;
                efail_q <= 1'b0;
            end
            if (prog_fail)  pfail_q <= 1'b1;
            if (erase_fail) efail_q <= 1'b1;
        end
    end

    // Assemble the live byte; power-down forces every bit low.
    always_comb begin
        live = STAT_ZERO;
        if (!pwr_down) begin
            live.ready = !busy_q;
            live.susp  = susp_q;
            live.efail = efail_q;
            live.pfail = pfail_q;
        end
    end

    assign busy    = busy_q;
    assign inhibit = pfail_q || efail_q;

    assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pfail_q && !clr_stat && !pwr_down) |=> pfail_q);

    assert_start_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && eng_start && !busy_q && !susp_q && !pwr_down) |=> !busy_q);

    assert_susp_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_q) |-> busy_q);

    assert_done_and_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && prog_fail && busy_q && !pwr_down) |=> (!busy_q && pfail_q));
endmodule

// File: rtl/wsm_stat_snap.sv
// Module: read snapshot. Captures the live byte on the rising edge of the
// read strobe and holds it for the rest of the access. Power-down clears it.
module wsm_stat_snap
    import wsm_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       rd_strobe,
    input  stat_byte_t live,
    output stat_byte_t snap
);
    logic       rd_q;
    stat_byte_t snap_q;

    // Edge-detect the strobe and latch the live value on its rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            snap_q <= STAT_IDLE;
        end else begin
            rd_q <= rd_strobe;
            if (pwr_down)
                snap_q <= STAT_ZERO;
            else if (rd_strobe && !rd_q)
                snap_q <= live;
        end
    end

    assign snap = snap_q;

    assert_snap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && rd_strobe && !pwr_down) |=> $stable(snap_q));
endmodule

// File: rtl/wsm_stat_fmt.sv
// Module: bus formatting. Zero-pads the status byte to the data width and
// reports whether the upper lanes are driven. Assumes DATA_W >= STAT_W.
module wsm_stat_fmt
    import wsm_stat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              word_mode,
    input  stat_byte_t        snap,
    output logic [DATA_W-1:0] data,
    output logic              upper_en
);
    localparam int HI_W = DATA_W - STAT_W;

    generate
        if (HI_W > 0) begin : g_wide
            // Upper lanes always carry zero; driven only in word mode.
            assign data     = {{HI_W{1'b0}}, snap.ready, snap.susp,
                               snap.efail, snap.pfail, 4'h0};
            assign upper_en = word_mode;
        end else begin : g_narrow
            // Byte-only bus: no upper lanes exist.
            assign data     = {snap.ready, snap.susp, snap.efail, snap.pfail, 4'h0};
            assign upper_en = 1'b0 & word_mode;
        end
    endgenerate
endmodule

// File: rtl/wsm_status_reg.sv
// Module: top of the engine status register. Combines live state, read
// snapshot and bus formatting; drives ready/busy level and start inhibit.
// Assumes all event inputs are synchronous one-cycle pulses.
module wsm_status_reg
    import wsm_stat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              word_mode,
    input  logic              eng_start,
    input  logic              start_erase,
    input  logic              eng_done,
    input  logic              prog_fail,
    input  logic              erase_fail,
    input  logic              susp_req,
    input  logic              susp_ack,
    input  logic              resume_req,
    input  logic              clr_stat,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] stat_data,
    output logic              upper_en,
    output logic              rdy_level,
    output logic              op_inhibit
);
    stat_byte_t live, snap;
    logic       busy;

    wsm_stat_bits u_bits (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .eng_start(eng_start), .start_erase(start_erase), .eng_done(eng_done),
        .prog_fail(prog_fail), .erase_fail(erase_fail),
        .susp_req(susp_req), .susp_ack(susp_ack), .resume_req(resume_req),
        .clr_stat(clr_stat), .live(live), .busy(busy), .inhibit(op_inhibit)
    );

    wsm_stat_snap u_snap (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .rd_strobe(rd_strobe), .live(live), .snap(snap)
    );

    wsm_stat_fmt #(.DATA_W(DATA_W)) u_fmt (
        .word_mode(word_mode), .snap(snap), .data(stat_data), .upper_en(upper_en)
    );

    // Open-drain style level: released unless the engine is actively busy.
    assign rdy_level = pwr_down || !busy;

    assert_pd_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (stat_data[7:0] == 8'h00));

    assert_low_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !pwr_down) |=> (stat_data[3:0] == 4'h0));
endmodule

// File: tb/sim_wsm_status_reg.sv
module sim_wsm_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0, word_mode = 1'b1, start_erase = 1'b0, rd_strobe = 1'b0;
    logic        eng_start = 1'b0, eng_done = 1'b0, prog_fail = 1'b0, erase_fail = 1'b0;
    logic        susp_req = 1'b0, susp_ack = 1'b0, resume_req = 1'b0, clr_stat = 1'b0;
    logic [15:0] stat_data;
    logic        upper_en, rdy_level, op_inhibit;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    wsm_status_reg #(.DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .word_mode(word_mode),
        .eng_start(eng_start), .start_erase(start_erase), .eng_done(eng_done),
        .prog_fail(prog_fail), .erase_fail(erase_fail), .susp_req(susp_req),
        .susp_ack(susp_ack), .resume_req(resume_req), .clr_stat(clr_stat),
        .rd_strobe(rd_strobe), .stat_data(stat_data), .upper_en(upper_en),
        .rdy_level(rdy_level), .op_inhibit(op_inhibit)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle event pulse; bit order: start,done,pfail,efail,sreq,sack,resume,clr
    task automatic ev(input logic [7:0] m);
        @(negedge clk);
        {eng_start, eng_done, prog_fail, erase_fail, susp_req, susp_ack, resume_req, clr_stat} = m;
        @(negedge clk);
        {eng_start, eng_done, prog_fail, erase_fail, susp_req, susp_ack, resume_req, clr_stat} = '0;
    endtask

    task automatic rd(output logic [15:0] v);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); v = stat_data; rd_strobe = 1'b0;
    endtask

    localparam logic [7:0] E_ST = 8'h80, E_DN = 8'h40, E_PF = 8'h20, E_EF = 8'h10,
                           E_SQ = 8'h08, E_SA = 8'h04, E_RS = 8'h02, E_CL = 8'h01;

    task automatic t_reset();
        chk("R1 data", stat_data, 16'h0080);
        chk("R1 rdy", {15'd0, rdy_level}, 16'd1);
        chk("R1 inhibit", {15'd0, op_inhibit}, 16'd0);
        chk("R2 upper_en word", {15'd0, upper_en}, 16'd1);
    endtask

    task automatic t_program();
        logic [15:0] v;
        start_erase = 1'b0;
        ev(E_ST);
        chk("R3 rdy busy", {15'd0, rdy_level}, 16'd0);
        rd(v); chk("R3 busy read", v, 16'h0000);
        ev(E_DN);
        chk("R3 rdy done", {15'd0, rdy_level}, 16'd1);
        rd(v); chk("R3 done read", v, 16'h0080);
    endtask

    task automatic t_snapshot();
        logic [15:0] v;
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); chk("R8 capture", stat_data, 16'h0080);
        ev(E_ST);
        chk("R8 held during access", stat_data, 16'h0080);
        @(negedge clk); rd_strobe = 1'b0;
        rd(v); chk("R8 next access", v, 16'h0000);
        ev(E_DN);
    endtask

    task automatic t_suspend();
        logic [15:0] v;
        start_erase = 1'b1;
        ev(E_ST);
        ev(E_SQ);
        rd(v); chk("R6 suspending", v, 16'h0040);
        chk("R6 rdy still low", {15'd0, rdy_level}, 16'd0);
        ev(E_SA);
        chk("R6 rdy suspended", {15'd0, rdy_level}, 16'd1);
        rd(v); chk("R6 suspended read", v, 16'h00C0);
        ev(E_RS);
        rd(v); chk("R7 resumed read", v, 16'h0000);
        chk("R7 rdy resumed", {15'd0, rdy_level}, 16'd0);
        ev(E_DN);
        ev(E_RS);
        rd(v); chk("R7 resume idle no effect", v, 16'h0080);
        chk("R7 rdy idle", {15'd0, rdy_level}, 16'd1);
        start_erase = 1'b0;
        ev(E_ST);
        ev(E_SQ);
        rd(v); chk("R6 suspend in program ignored", v, 16'h0000);
        ev(E_DN);
    endtask

    task automatic t_fail();
        logic [15:0] v;
        ev(E_ST);
        ev(E_PF);
        rd(v); chk("R4 fail while busy", v, 16'h0010);
        ev(E_DN);
        rd(v); chk("R4 fail survives done", v, 16'h0090);
        chk("R5 inhibit", {15'd0, op_inhibit}, 16'd1);
        ev(E_ST);
        chk("R5 rdy stays high", {15'd0, rdy_level}, 16'd1);
        rd(v); chk("R5 start ignored", v, 16'h0090);
        ev(E_CL);
        rd(v); chk("R4 cleared", v, 16'h0080);
        chk("R4 inhibit released", {15'd0, op_inhibit}, 16'd0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        start_erase = 1'b1;
        ev(E_ST);
        ev(E_DN | E_EF);
        rd(v); chk("R9 done with erase fail", v, 16'h00A0);
        ev(E_CL | E_PF);
        rd(v); chk("R4 set beats clear", v, 16'h0090);
        ev(E_CL);
        rd(v); chk("R4 clear", v, 16'h0080);
    endtask

    task automatic t_byte_mode();
        logic [15:0] v;
        @(negedge clk); word_mode = 1'b0;
        #1; chk("R2 upper_en byte", {15'd0, upper_en}, 16'd0);
        rd(v); chk("R2 byte data", v, 16'h0080);
        word_mode = 1'b1;
    endtask

    task automatic t_power_down();
        logic [15:0] v;
        start_erase = 1'b1;
        ev(E_ST);
        ev(E_PF);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk);
        chk("R10 data cleared", stat_data, 16'h0000);
        chk("R10 rdy high", {15'd0, rdy_level}, 16'd1);
        chk("R10 inhibit low", {15'd0, op_inhibit}, 16'd0);
        rd(v); chk("R10 read in pd", v, 16'h0000);
        @(negedge clk); pwr_down = 1'b0;
        rd(v); chk("R10 after release", v, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_snapshot();
        t_suspend();
        t_fail();
        t_same_cycle();
        t_byte_mode();
        t_power_down();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule